// File: doc/BRIEF.md
# Multi-Controller Interrupt Vector Arbiter

This block merges the interrupt status of up to four eight-line serial multiplexer controllers into a single bus interrupt request. It also supplies the vector that the processor reads when it acknowledges that request. Each controller presents six status bits:

- transmit interrupt enable
- transmitter ready
- silo alarm enable
- silo alarm
- receive interrupt enable
- receive done

A programmable base vector is shared by all controllers.

Each controller owns two vectors eight apart from its neighbour's pair: a receive vector at `base + 8*i` and a transmit vector four above it. The request output is registered and follows the pending state one clock later. The vector output is combinational from the present status, so the bus side may sample it on its acknowledge strobe. Bus grant timing is outside this block, and so is the register logic that produces the status bits. Both interfaces are plain level signals with no handshake: the status bits are not a data stream, and the vector is only meaningful at the instant the bus samples it.

Top module: `irq_vector_arbiter`

## Requirements
- R1: Controller i has a transmit condition when both `tx_int_en[i]` and `tx_ready[i]` are 1.
- R2: Controller i has a receive condition when both `alarm_en[i]` and `alarm_flag[i]` are 1.
- R3: Controller i also has a receive condition when `rx_int_en[i]` and `rx_done[i]` are 1 and `alarm_en[i]` is 0. While `alarm_en[i]` is 1, `rx_done[i]` has no effect.
- R4: `irq_req` is a register. On each rising clock edge it takes 1 if any controller had a condition just before that edge, and 0 otherwise.
- R5: Among controllers with a condition, the lowest index decides the vector. Controller i returns `base_vec + 8*i` (modulo 2^VEC_W) for a receive condition.
- R6: A controller with only a transmit condition returns `base_vec + 8*i + 4`. A receive condition on the same controller takes precedence.
- R7: With no condition on any controller, `ack_vec` is 0.
- R8: While `rst_n` is 0, `irq_req` is 0 whatever the status inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_int_en | input | N_CTRL | Transmit interrupt enable, one bit per controller |
| tx_ready | input | N_CTRL | Transmitter ready, one bit per controller |
| alarm_en | input | N_CTRL | Silo alarm enable, one bit per controller |
| alarm_flag | input | N_CTRL | Silo alarm, one bit per controller |
| rx_int_en | input | N_CTRL | Receive interrupt enable, one bit per controller |
| rx_done | input | N_CTRL | Receive done, one bit per controller |
| base_vec | input | VEC_W | Programmable base vector |
| irq_req | output | 1 | Registered bus interrupt request |
| ack_vec | output | VEC_W | Vector to return at acknowledge (combinational) |

## Verification
The assertions take for granted that the status bits and the base vector are synchronous to `clk` and settle well before each rising edge. Without that, neither the one-cycle request lag nor the combinational vector would be well defined. The stimulus changes every input only at the falling edge and holds it until the following falling edge. Random bits are drawn with a bias toward zero, so idle cycles, single-controller cycles and crowded cycles all occur. Base values cover the whole vector range, including values where the sum wraps.

// File: rtl/iva_pkg.sv
package iva_pkg;
  // Per-controller decoded interrupt condition
  typedef struct packed {
    logic rx;
    logic tx;
  } ctrl_cond_t;

  localparam int unsigned CTRL_STRIDE = 8;  // vector spacing between controllers
  localparam int unsigned XMT_OFFSET  = 4;  // transmit vector above receive vector
endpackage

// File: rtl/iva_cond_decode.sv
module iva_cond_decode
  import iva_pkg::*;
(
  input  logic       tx_int_en,
  input  logic       tx_ready,
  input  logic       alarm_en,
  input  logic       alarm_flag,
  input  logic       rx_int_en,
  input  logic       rx_done,
  output ctrl_cond_t cond
);
  logic alarm_hit;
  logic done_hit;

  always_comb begin
    alarm_hit = alarm_en & alarm_flag;
    // receive-done only counts when silo alarm mode is off
    done_hit  = rx_int_en & rx_done & ~alarm_en;
    cond.rx   = alarm_hit | done_hit;
    cond.tx   = tx_int_en & tx_ready;
  end
endmodule

// File: rtl/iva_vec_select.sv
module iva_vec_select
  import iva_pkg::*;
#(
  parameter int unsigned N_CTRL = 4,
  parameter int unsigned VEC_W  = 9
) (
  input  logic [N_CTRL-1:0] rx_pend,
  input  logic [N_CTRL-1:0] tx_pend,
  input  logic [VEC_W-1:0]  base_vec,
  output logic [VEC_W-1:0]  vec,
  output logic              any_pend
);
  // Offset of each controller's receive vector
  logic [VEC_W-1:0] rx_ofs [N_CTRL];
  logic [VEC_W-1:0] tx_ofs [N_CTRL];

  for (genvar g = 0; g < N_CTRL; g++) begin : g_ofs
    assign rx_ofs[g] = VEC_W'(g * CTRL_STRIDE);
    assign tx_ofs[g] = VEC_W'(g * CTRL_STRIDE + XMT_OFFSET);
  end

  always_comb begin
    vec = '0;
    // walk from highest to lowest so the lowest index wins
    for (int i = N_CTRL - 1; i >= 0; i--) begin
      if (rx_pend[i])      vec = base_vec + rx_ofs[i];
      else if (tx_pend[i]) vec = base_vec + tx_ofs[i];
    end
    any_pend = |(rx_pend | tx_pend);
  end
endmodule

// File: rtl/iva_req_reg.sv
module iva_req_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic any_pend,
  output logic irq_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_req <= 1'b0;
    else        irq_req <= any_pend;
  end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import iva_pkg::*;
#(
  parameter int unsigned N_CTRL = 4,
  parameter int unsigned VEC_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CTRL-1:0] tx_int_en,
  input  logic [N_CTRL-1:0] tx_ready,
  input  logic [N_CTRL-1:0] alarm_en,
  input  logic [N_CTRL-1:0] alarm_flag,
  input  logic [N_CTRL-1:0] rx_int_en,
  input  logic [N_CTRL-1:0] rx_done,
  input  logic [VEC_W-1:0]  base_vec,
  output logic              irq_req,
  output logic [VEC_W-1:0]  ack_vec
);
  ctrl_cond_t        cond [N_CTRL];
  logic [N_CTRL-1:0] rx_pend;
  logic [N_CTRL-1:0] tx_pend;
  logic              any_pend;

  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    iva_cond_decode u_dec (
      .tx_int_en (tx_int_en[g]),
      .tx_ready  (tx_ready[g]),
      .alarm_en  (alarm_en[g]),
      .alarm_flag(alarm_flag[g]),
      .rx_int_en (rx_int_en[g]),
      .rx_done   (rx_done[g]),
      .cond      (cond[g])
    );
    assign rx_pend[g] = cond[g].rx;
    assign tx_pend[g] = cond[g].tx;
  end

  iva_vec_select #(.N_CTRL(N_CTRL), .VEC_W(VEC_W)) u_sel (
    .rx_pend (rx_pend),
    .tx_pend (tx_pend),
    .base_vec(base_vec),
    .vec     (ack_vec),
    .any_pend(any_pend)
  );

  iva_req_reg u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_pend(any_pend),
    .irq_req (irq_req)
  );
endmodule

// File: rtl/iva_checker.sv
module iva_checker #(
  parameter int unsigned N_CTRL = 4,
  parameter int unsigned VEC_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_CTRL-1:0] tx_int_en,
  input logic [N_CTRL-1:0] tx_ready,
  input logic [N_CTRL-1:0] alarm_en,
  input logic [N_CTRL-1:0] alarm_flag,
  input logic [N_CTRL-1:0] rx_int_en,
  input logic [N_CTRL-1:0] rx_done,
  input logic [VEC_W-1:0]  base_vec,
  input logic              irq_req,
  input logic [VEC_W-1:0]  ack_vec
);
  logic [N_CTRL-1:0] rx_c;
  logic [N_CTRL-1:0] tx_c;
  logic              pend;

  assign rx_c = (alarm_en & alarm_flag) | (rx_int_en & rx_done & ~alarm_en);
  assign tx_c = tx_int_en & tx_ready;
  assign pend = |(rx_c | tx_c);

  AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_req == $past(pend)));  // R4
  AST_IDLE_ZERO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |-> (ack_vec == '0));  // R7
  AST_CTRL0_RX_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    rx_c[0] |-> (ack_vec == base_vec));  // R5
  AST_CTRL0_TX_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_c[0] && !rx_c[0]) |-> (ack_vec == VEC_W'(base_vec + 4)));  // R6
  AST_ALARM_MASKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_en[0] && !alarm_flag[0] && !tx_c[0] && rx_c[N_CTRL-1:1] == '0
     && tx_c[N_CTRL-1:1] == '0) |-> (ack_vec == '0));  // R3
endmodule

bind irq_vector_arbiter iva_checker #(.N_CTRL(N_CTRL), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_int_en(tx_int_en), .tx_ready(tx_ready),
  .alarm_en(alarm_en), .alarm_flag(alarm_flag), .rx_int_en(rx_int_en),
  .rx_done(rx_done), .base_vec(base_vec), .irq_req(irq_req), .ack_vec(ack_vec)
);

// File: tb/irq_vector_arbiter_tb.sv
`timescale 1ns/1ps
module irq_vector_arbiter_tb_top;
  localparam int N = 4;
  localparam int W = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] tie = '0, trdy = '0, sae = '0, sa = '0, rie = '0, rdn = '0;
  logic [W-1:0] base = '0;
  logic         irq_req;
  logic [W-1:0] ack_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_vector_arbiter #(.N_CTRL(N), .VEC_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_int_en(tie), .tx_ready(trdy),
    .alarm_en(sae), .alarm_flag(sa), .rx_int_en(rie), .rx_done(rdn),
    .base_vec(base), .irq_req(irq_req), .ack_vec(ack_vec)
  );

  function automatic logic [W-1:0] model_vec();
    for (int i = 0; i < N; i++) begin
      if ((sae[i] && sa[i]) || (rie[i] && rdn[i] && !sae[i]))
        return W'(base + 8 * i);
      if (tie[i] && trdy[i])
        return W'(base + 8 * i + 4);
    end
    return '0;
  endfunction

  function automatic bit model_any();
    for (int i = 0; i < N; i++)
      if ((sae[i] && sa[i]) || (rie[i] && rdn[i] && !sae[i]) || (tie[i] && trdy[i]))
        return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    tie = '0; trdy = '0; sae = '0; sa = '0; rie = '0; rdn = '0;
  endtask

  // inputs already applied after a negedge; checks vector now, request after the edge
  task automatic step(input string req);
    logic [W-1:0] ev;
    bit ea;
    ev = model_vec();
    ea = model_any();
    #0.5;
    check({req, " vec"}, ack_vec, ev);
    @(posedge clk);
    #0.5;
    check("R4 irq", W'(irq_req), W'(ea));
    @(negedge clk);
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'd1357);
    // R8: reset holds request low even with a pending condition
    @(negedge clk);
    tie = 4'b0001; trdy = 4'b0001; base = 9'd64;
    @(posedge clk); #0.5;
    check("R8 reset irq", W'(irq_req), '0);
    @(negedge clk);
    rst_n = 1'b1;
    clear_all();
    step("R7 idle");
    // R1: transmit only on controller 2
    tie = 4'b0100; trdy = 4'b0100; base = 9'd64;
    step("R1 tx ctrl2");
    // R1: enable without ready gives nothing
    clear_all(); tie = 4'b1111; trdy = 4'b0000;
    step("R1 enable only");
    // R2: silo alarm on controller 1
    clear_all(); sae = 4'b0010; sa = 4'b0010;
    step("R2 alarm ctrl1");
    // R3: receive-done on controller 3 with alarm mode off
    clear_all(); rie = 4'b1000; rdn = 4'b1000;
    step("R3 done ctrl3");
    // R3: alarm mode on masks receive-done
    sae = 4'b1000;
    step("R3 done masked");
    // R5: controllers 1 and 3 both receive; lowest wins
    clear_all(); rie = 4'b1010; rdn = 4'b1010;
    step("R5 lowest index");
    // R6: receive beats transmit within controller 0
    clear_all(); tie = 4'b0001; trdy = 4'b0001; sae = 4'b0001; sa = 4'b0001;
    step("R6 rx over tx");
    // R6: transmit on 0 beats receive on 2
    clear_all(); tie = 4'b0001; trdy = 4'b0001; rie = 4'b0100; rdn = 4'b0100;
    step("R6 tx ctrl0 vs rx ctrl2");
    // R5: wrap of base plus offset
    clear_all(); base = 9'd508; tie = 4'b1000; trdy = 4'b1000;
    step("R5 wrap");
    clear_all();
    step("R7 idle again");
    // random mix
    for (int k = 0; k < 400; k++) begin
      tie  = N'($urandom & $urandom);
      trdy = N'($urandom & $urandom);
      sae  = N'($urandom & $urandom);
      sa   = N'($urandom);
      rie  = N'($urandom & $urandom);
      rdn  = N'($urandom);
      base = W'($urandom);
      step("R5 random");
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule